// File: doc/BRIEF.md
# Chip-Select Inter-Access Gap Controller

This block sits between the external-bus access arbiter and the per-chip-select cycle generators. It holds the winning request back until enough idle clocks have passed since the previous access finished, and then grants it. The number of idle clocks depends on the previous access: which chip-select it used, whether it read or wrote, and whether it belonged to a prefetch stream. Each chip-select has its own settings for the gap.

Each chip-select has two optional gaps. The repeat gap applies when the same chip-select is used again, for example so that a status read can follow a status command write. The turnaround gap belongs to the previous chip-select. It lets that device release the data bus before another device, or a write from the controller, drives it. When both gaps apply, the larger one is used. Two prefetch accesses in a row to the same chip-select skip every gap. The block marks that grant so the cycle generator can apply its shortened back-to-back timing.

The arbiter holds a request until it is granted. The cycle generator pulses `acc_done` in the last clock of the access. Idle clocks are counted from the clock after that pulse.

Top module: `csgap_ctrl`

## Requirements
- R1: After reset, the first request is granted in the same clock it is presented, with no gap.
- R2: No grant is given from the clock of a grant up to and including the clock of the matching `acc_done` pulse. At most one grant is given per access.
- R3: The chip-select repeats and a write precedes the next access: the request is granted in the first clock in which at least `cfg_same_dly[cs]` idle clocks have passed. This holds if `cfg_same_en[cs]` is set; otherwise the gap is zero. The field of chip-select `cs` is bits `[4*cs+3:4*cs]`.
- R4: The chip-select changes: the gap is `cfg_ta_dly[prev]` if `cfg_ta_en[prev]` is set, and zero otherwise. Here `prev` is the chip-select of the previous access.
- R5: A read that follows a read on the same chip-select never waits for the turnaround gap.
- R6: A write that follows a read on the same chip-select waits for the larger of the repeat gap and the turnaround gap of that chip-select, not for their sum.
- R7: When the previous access and the new request both carry `req_pf` and use the same chip-select, the request is granted with no gap and `fast_timing` is 1 in the grant clock.
- R8: `fast_timing` is 0 in every clock without a grant, and in every grant that is not part of such a prefetch stream.
- R9: With both enables of the relevant chip-selects cleared, every access is granted with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request pending, held until granted |
| req_cs | input | 2 | Chip-select of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_pf | input | 1 | Request comes from the prefetch stream |
| acc_done | input | 1 | Last clock of the granted access |
| cfg_same_en | input | 4 | Per chip-select repeat gap enable |
| cfg_same_dly | input | 16 | Per chip-select repeat gap, 4 bits each |
| cfg_ta_en | input | 4 | Per chip-select turnaround enable |
| cfg_ta_dly | input | 16 | Per chip-select turnaround gap, 4 bits each |
| grant | output | 1 | Request accepted in this clock |
| fast_timing | output | 1 | The granted access may use shortened back-to-back timing |

## Verification
The assertions assume that `acc_done` comes only while an access is in flight. They also assume that the request and the configuration stay stable while the request waits. The bench issues `acc_done` only a few clocks after each grant. It holds the request fields until the grant, and it changes the configuration only between accesses. Random waits before each request, together with gap values up to 15, exercise both cases: grants held back by the gap, and requests that arrive after the gap has already passed.

// File: rtl/csgap_pkg.sv
package csgap_pkg;
  // Turnaround applies when the bus owner changes or when a read is
  // followed by a write on the same chip-select.
  function automatic logic ta_needed(logic same_cs, logic prev_wr, logic next_wr);
    return !same_cs || (!prev_wr && next_wr);
  endfunction

  // Overlapping gaps: the larger one covers both.
  function automatic int unsigned gap_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/csgap_history.sv
module csgap_history #(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant,
  input  logic [CS_W-1:0] req_cs,
  input  logic            req_wr,
  input  logic            req_pf,
  input  logic            acc_done,
  output logic            busy,
  output logic            hist_vld,
  output logic [CS_W-1:0] prev_cs,
  output logic            prev_wr,
  output logic            prev_pf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hist_vld <= 1'b0;
      prev_cs  <= '0;
      prev_wr  <= 1'b0;
      prev_pf  <= 1'b0;
    end else if (busy && acc_done) begin
      busy <= 1'b0;
    end else if (grant) begin
      busy     <= 1'b1;
      hist_vld <= 1'b1;
      prev_cs  <= req_cs;
      prev_wr  <= req_wr;
      prev_pf  <= req_pf;
    end
  end
endmodule

// File: rtl/csgap_idle_timer.sv
module csgap_idle_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             acc_done,
  output logic [DLY_W-1:0] idle_cnt
);
  localparam logic [DLY_W-1:0] CNT_MAX = '1;

  // Counts idle clocks since the last access ended, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_cnt <= CNT_MAX;
    else if (busy && acc_done)
      idle_cnt <= '0;
    else if (!busy && idle_cnt != CNT_MAX)
      idle_cnt <= idle_cnt + 1'b1;
  end
endmodule

// File: rtl/csgap_gap_calc.sv
module csgap_gap_calc
  import csgap_pkg::*;
#(
  parameter int N_CS  = 4,
  parameter int DLY_W = 4,
  parameter int CS_W  = 2
) (
  input  logic                  hist_vld,
  input  logic [CS_W-1:0]       prev_cs,
  input  logic                  prev_wr,
  input  logic                  prev_pf,
  input  logic [CS_W-1:0]       req_cs,
  input  logic                  req_wr,
  input  logic                  req_pf,
  input  logic [N_CS-1:0]       cfg_same_en,
  input  logic [N_CS*DLY_W-1:0] cfg_same_dly,
  input  logic [N_CS-1:0]       cfg_ta_en,
  input  logic [N_CS*DLY_W-1:0] cfg_ta_dly,
  output logic [DLY_W-1:0]      need_gap,
  output logic                  stream_hit
);
  logic [DLY_W-1:0] same_dly_a [N_CS];
  logic [DLY_W-1:0] ta_dly_a   [N_CS];

  for (genvar g = 0; g < N_CS; g++) begin : g_unpack
    assign same_dly_a[g] = cfg_same_dly[g*DLY_W +: DLY_W];
    assign ta_dly_a[g]   = cfg_ta_dly[g*DLY_W +: DLY_W];
  end

  logic             same_cs;
  logic [DLY_W-1:0] rep_gap;
  logic [DLY_W-1:0] ta_gap;

  always_comb begin
    same_cs    = (req_cs == prev_cs);
    stream_hit = hist_vld && same_cs && prev_pf && req_pf;
    rep_gap    = (same_cs && cfg_same_en[req_cs]) ? same_dly_a[req_cs] : '0;
    ta_gap     = (ta_needed(same_cs, prev_wr, req_wr) && cfg_ta_en[prev_cs])
                 ? ta_dly_a[prev_cs] : '0;
    if (!hist_vld || stream_hit)
      need_gap = '0;
    else
      need_gap = DLY_W'(gap_max(int'(rep_gap), int'(ta_gap)));
  end
endmodule

// File: rtl/csgap_ctrl.sv
module csgap_ctrl #(
  parameter int N_CS  = 4,
  parameter int DLY_W = 4,
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [CS_W-1:0]       req_cs,
  input  logic                  req_wr,
  input  logic                  req_pf,
  input  logic                  acc_done,
  input  logic [N_CS-1:0]       cfg_same_en,
  input  logic [N_CS*DLY_W-1:0] cfg_same_dly,
  input  logic [N_CS-1:0]       cfg_ta_en,
  input  logic [N_CS*DLY_W-1:0] cfg_ta_dly,
  output logic                  grant,
  output logic                  fast_timing
);
  logic             busy;
  logic             hist_vld;
  logic [CS_W-1:0]  prev_cs;
  logic             prev_wr;
  logic             prev_pf;
  logic [DLY_W-1:0] idle_cnt;
  logic [DLY_W-1:0] need_gap;
  logic             stream_hit;
  logic             gap_met;

  csgap_history #(.CS_W(CS_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .grant(grant),
    .req_cs(req_cs), .req_wr(req_wr), .req_pf(req_pf), .acc_done(acc_done),
    .busy(busy), .hist_vld(hist_vld),
    .prev_cs(prev_cs), .prev_wr(prev_wr), .prev_pf(prev_pf)
  );

  csgap_idle_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(busy), .acc_done(acc_done),
    .idle_cnt(idle_cnt)
  );

  csgap_gap_calc #(.N_CS(N_CS), .DLY_W(DLY_W), .CS_W(CS_W)) u_calc (
    .hist_vld(hist_vld), .prev_cs(prev_cs), .prev_wr(prev_wr), .prev_pf(prev_pf),
    .req_cs(req_cs), .req_wr(req_wr), .req_pf(req_pf),
    .cfg_same_en(cfg_same_en), .cfg_same_dly(cfg_same_dly),
    .cfg_ta_en(cfg_ta_en), .cfg_ta_dly(cfg_ta_dly),
    .need_gap(need_gap), .stream_hit(stream_hit)
  );

  assign gap_met     = (idle_cnt >= need_gap);
  assign grant       = req_valid && !busy && gap_met;
  assign fast_timing = grant && stream_hit;
endmodule

// File: rtl/csgap_ctrl_chk.sv
module csgap_ctrl_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grant,
  input logic             fast_timing,
  input logic             acc_done,
  input logic             busy,
  input logic             hist_vld,
  input logic [DLY_W-1:0] idle_cnt,
  input logic [DLY_W-1:0] need_gap
);
  AST_NO_GRANT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !grant); // R2
  AST_GRANT_OPENS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> busy); // R2
  AST_DONE_RESTARTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_done) |=> (!busy && idle_cnt == '0)); // R3
  AST_IDLE_FROZEN_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acc_done) |=> $stable(idle_cnt)); // R3
  AST_GAP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && hist_vld) |-> (idle_cnt >= need_gap)); // R4
  AST_FAST_ONLY_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    fast_timing |-> (grant && need_gap == '0)); // R8
  AST_FIRST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_vld |-> (need_gap == '0)); // R1
endmodule

bind csgap_ctrl csgap_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .fast_timing(fast_timing),
  .acc_done(acc_done), .busy(busy), .hist_vld(hist_vld),
  .idle_cnt(idle_cnt), .need_gap(need_gap)
);

// File: tb/csgap_ctrl_bench.sv
`timescale 1ns/1ps
module csgap_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cs = '0;
  logic        req_wr = 1'b0;
  logic        req_pf = 1'b0;
  logic        acc_done = 1'b0;
  logic [3:0]  same_en = '0;
  logic [3:0]  ta_en = '0;
  logic [3:0]  same_d [4];
  logic [3:0]  ta_d [4];
  logic [15:0] same_dly_v;
  logic [15:0] ta_dly_v;
  logic        grant;
  logic        fast_timing;

  int tests = 0;
  int fails = 0;

  // model state
  bit       m_busy = 0;
  bit       m_have = 0;
  bit [1:0] m_pcs = 0;
  bit       m_pwr = 0;
  bit       m_ppf = 0;
  int       m_idle = 15;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      same_dly_v[i*4 +: 4] = same_d[i];
      ta_dly_v[i*4 +: 4]   = ta_d[i];
    end
  end

  csgap_ctrl u_csgap_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
    .req_wr(req_wr), .req_pf(req_pf), .acc_done(acc_done),
    .cfg_same_en(same_en), .cfg_same_dly(same_dly_v),
    .cfg_ta_en(ta_en), .cfg_ta_dly(ta_dly_v),
    .grant(grant), .fast_timing(fast_timing)
  );

  function automatic bit m_stream(bit [1:0] cs, bit pf);
    return m_have && (cs == m_pcs) && m_ppf && pf;
  endfunction

  function automatic int m_need(bit [1:0] cs, bit wr, bit pf);
    int rep, ta;
    rep = 0;
    ta  = 0;
    if (!m_have || m_stream(cs, pf)) return 0;
    if (cs == m_pcs && same_en[cs]) rep = same_d[cs];
    if (cs != m_pcs && ta_en[m_pcs]) ta = ta_d[m_pcs];
    if (cs == m_pcs && !m_pwr && wr && ta_en[m_pcs]) ta = ta_d[m_pcs];
    return (rep > ta) ? rep : ta;
  endfunction

  function automatic string m_tag(bit [1:0] cs, bit wr, bit pf);
    if (!m_have) return "R1";
    if (m_busy) return "R2";
    if (m_stream(cs, pf)) return "R7";
    if (cs == m_pcs && !m_pwr && wr) return "R6";
    if (cs == m_pcs && !m_pwr && !same_en[cs]) return "R5";
    if (cs == m_pcs && !same_en[cs]) return "R9";
    if (cs == m_pcs) return "R3";
    if (!ta_en[m_pcs]) return "R9";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit [1:0] cs, input bit wr, input bit pf,
                      input bit dn, output bit got);
    int  need;
    bit  eg, er;
    @(negedge clk);
    req_valid = v; req_cs = cs; req_wr = wr; req_pf = pf; acc_done = dn;
    #1;
    need = m_need(cs, wr, pf);
    eg   = v && !m_busy && (m_idle >= need);
    er   = eg && m_stream(cs, pf);
    check(grant == eg, m_tag(cs, wr, pf), "grant", int'(grant), int'(eg));
    check(fast_timing == er, er ? "R7" : "R8", "fast_timing", int'(fast_timing), int'(er));
    got = eg;
    if (dn && m_busy) begin
      m_busy = 0; m_idle = 0;
    end else if (eg) begin
      m_busy = 1; m_have = 1; m_pcs = cs; m_pwr = wr; m_ppf = pf;
    end else if (!m_busy && m_idle < 15) begin
      m_idle++;
    end
  endtask

  task automatic access(input bit [1:0] cs, input bit wr, input bit pf,
                        input int pre_wait, input int len);
    bit got;
    got = 0;
    for (int i = 0; i < pre_wait; i++) step(0, cs, wr, pf, 0, got);
    for (int i = 0; i < 40 && !got; i++) step(1, cs, wr, pf, 0, got);
    if (!got) check(0, "R3", "grant timeout", 0, 1);
    for (int i = 0; i < len; i++) step(0, cs, wr, pf, 0, got);
    step(0, cs, wr, pf, 1, got);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit dummy;
    void'($urandom(32'd7391));
    for (int i = 0; i < 4; i++) begin same_d[i] = '0; ta_d[i] = '0; end
    // reset state
    repeat (3) @(negedge clk);
    check(grant == 1'b0 && fast_timing == 1'b0, "R1", "reset outputs",
          int'({grant, fast_timing}), 0);
    rst_n = 1'b1;
    // directed configuration
    same_en = 4'b0101; same_d[0] = 5; same_d[2] = 2;
    ta_en   = 4'b0111; ta_d[0] = 3; ta_d[1] = 7; ta_d[2] = 6;
    access(0, 0, 0, 0, 2);   // R1: first access, no gap
    access(0, 1, 0, 0, 1);   // R6: read->write same cs, max(5,3)
    access(0, 0, 0, 0, 1);   // R3: write->read same cs, repeat gap 5
    access(1, 0, 0, 0, 2);   // R4: cs change, turnaround of cs0 = 3
    access(1, 0, 0, 0, 1);   // R5: read->read same cs, no turnaround
    access(1, 0, 1, 0, 1);
    access(1, 0, 1, 0, 1);   // R7: prefetch stream, fast timing
    access(3, 1, 0, 2, 1);   // R4: turnaround of cs1 = 7, partly elapsed
    access(3, 1, 0, 0, 1);   // R9: cs3 has nothing enabled
    access(2, 0, 0, 0, 1);   // R9: previous cs3 has no turnaround
    access(2, 1, 1, 0, 1);   // R6: max(2,6)
    access(2, 1, 1, 0, 3);   // R7: stream suppresses repeat gap
    // random phase
    for (int n = 0; n < 400; n++) begin
      if (n % 25 == 0) begin
        same_en = 4'($urandom); ta_en = 4'($urandom);
        for (int i = 0; i < 4; i++) begin
          same_d[i] = 4'($urandom); ta_d[i] = 4'($urandom);
        end
      end
      access(2'($urandom), 1'($urandom), 1'($urandom_range(0, 2) != 0),
             ($urandom_range(0, 3) == 0) ? $urandom_range(0, 18) : 0,
             $urandom_range(0, 3));
    end
    step(0, 0, 0, 0, 0, dummy);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule